// File: doc/BRIEF.md
# Synthesizer Serial Word Loader

This block programs a frequency synthesizer through a three-wire serial link: a shared serial clock, a shared serial data line and one latch-enable line per device. A single-cycle start request hands the block three configuration words. The first is the function/initialisation word, the second is the reference-divider word and the third is the feedback-divider word. The block then sends all three words on its own, latching each one into the chosen device.

Each word is trimmed to 24 bits and sent most significant bit first. Data changes only while the serial clock is low. After the last bit of a word, the enable line of the selected device pulses high, and then the next word begins.

A divider value is captured at start. It sets the number of system clocks in every serial-clock high phase, every low phase, every latch pulse and every idle gap. Several synthesizers can hang off the same clock and data pair, because a select input steers the latch pulse to exactly one of them.

Top module: `synth_word_loader`

## Requirements
- R1: Only bits 23..0 of each input word are transmitted; bits 31..24 have no effect on the serial data.
- R2: Each word is sent as 24 bits, bit 23 first and bit 0 last, one bit per serial-clock rising edge.
- R3: The words go out in a fixed order: function word, then reference word, then feedback word.
- R4: Out of reset, and from the first busy cycle until the first bit's low phase, serial clock, serial data and all latch enables are low.
- R5: For a divider value D, each serial-clock high phase lasts D system clocks and each low phase between bits of a word lasts D clocks. Serial data does not change while the serial clock is high.
- R6: After the 24th bit of each word, the enable selected by the device-select input, sampled at start (enable k for select value k), is high for D clocks while the serial clock is low. No other enable rises. A select value at or above the device count drives no enable.
- R7: Busy rises on the clock after an accepted start and stays high for exactly 150·D clocks. Done is high for exactly one cycle, the first cycle in which busy is low again.
- R8: A start request made while busy is ignored: the words, the select and the timing in progress are not changed, and no extra word is sent.
- R9: A divider value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a three-word transfer (accepted only while idle) |
| dev_sel | input | SEL_W (2) | Index of the device whose enable is pulsed |
| half_div | input | DIV_W (8) | System clocks per serial phase, 0 treated as 1 |
| func_word | input | IN_W (32) | Function/initialisation word, bits 23..0 used |
| ref_word | input | IN_W (32) | Reference-divider word, bits 23..0 used |
| ncnt_word | input | IN_W (32) | Feedback-divider word, bits 23..0 used |
| ser_clk | output | 1 | Shared serial clock |
| ser_data | output | 1 | Shared serial data |
| latch_en | output | NUM_DEV (3) | Per-device latch enables |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions watch, on every cycle:
- that data is stable while the serial clock is high;
- that at most one enable is high, and never together with the serial clock;
- that the lines stay quiet while idle;
- that done is a single cycle right after busy falls;
- that a start during busy leaves the captured select and divider untouched;
- that the phase counter and the shifter move as intended.

Only the bench's scenarios can show:
- the bit order, the word order and the dropping of the upper bits, by rebuilding each word from the serial edges;
- the exact phase and latch widths for several divider values, including 0 and 255;
- the total busy length;
- that an out-of-range select fires no enable.

// File: rtl/sl_pkg.sv
package sl_pkg;
  localparam int SL_NUM_WORDS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_LOW,
    ST_HIGH,
    ST_LATCH
  } sl_state_e;
endpackage

// File: rtl/sl_phase_timer.sv
module sl_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  // A zero divider is run as one clock per phase (R9)
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : d;
  endfunction

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = eff_div(div) - 1'b1;
  assign tick = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last));
  p_count_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/sl_word_shifter.sv
module sl_word_shifter #(
  parameter int WORD_W = 24,
  parameter int IN_W   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IN_W-1:0] load_word,
  input  logic            shift,
  output logic            msb
);
  // Upper input bits are dropped here (R1)
  function automatic logic [WORD_W-1:0] trim(input logic [IN_W-1:0] w);
    return w[WORD_W-1:0];
  endfunction

  logic [WORD_W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= trim(load_word);
    else if (shift) q <= {q[WORD_W-2:0], 1'b0};
  end

  assign msb = q[WORD_W-1];

  p_shift_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (msb == $past(q[WORD_W-2])));
endmodule

// File: rtl/sl_enable_decode.sv
module sl_enable_decode #(
  parameter int NUM_DEV = 3,
  parameter int SEL_W   = 2
) (
  input  logic               fire,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_DEV-1:0] en
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_en
    assign en[g] = fire && (sel == SEL_W'(g));
  end

  always_comb begin
    p_single_enable_r6: assert ($onehot0(en));
  end
endmodule

// File: rtl/synth_word_loader.sv
module synth_word_loader #(
  parameter int WORD_W  = 24,
  parameter int IN_W    = 32,
  parameter int NUM_DEV = 3,
  parameter int SEL_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SEL_W-1:0]   dev_sel,
  input  logic [DIV_W-1:0]   half_div,
  input  logic [IN_W-1:0]    func_word,
  input  logic [IN_W-1:0]    ref_word,
  input  logic [IN_W-1:0]    ncnt_word,
  output logic               ser_clk,
  output logic               ser_data,
  output logic [NUM_DEV-1:0] latch_en,
  output logic               busy,
  output logic               done
);
  import sl_pkg::*;

  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [1:0] LAST_WORD = 2'(SL_NUM_WORDS - 1);

  sl_state_e        state;
  logic [BIT_W-1:0] bit_idx;
  logic [1:0]       word_idx;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  logic [IN_W-1:0]  ref_q;
  logic [IN_W-1:0]  ncnt_q;
  logic             done_q;

  // Named internal events
  logic            tick;
  logic            accept;
  logic            word_end;
  logic            frame_end;
  logic            next_word;
  logic            shift_en;
  logic            load_en;
  logic [IN_W-1:0] load_word;
  logic            sh_msb;

  assign accept    = (state == ST_IDLE) && start;
  assign word_end  = (state == ST_HIGH) && tick && (bit_idx == LAST_BIT);
  assign shift_en  = (state == ST_HIGH) && tick && (bit_idx != LAST_BIT);
  assign frame_end = (state == ST_LATCH) && tick && (word_idx == LAST_WORD);
  assign next_word = (state == ST_LATCH) && tick && (word_idx != LAST_WORD);
  assign load_en   = accept || next_word;
  assign load_word = accept ? func_word : ((word_idx == 2'd0) ? ref_q : ncnt_q);

  sl_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state != ST_IDLE),
    .div   (div_q),
    .tick  (tick)
  );

  sl_word_shifter #(.WORD_W(WORD_W), .IN_W(IN_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_en),
    .load_word (load_word),
    .shift     (shift_en),
    .msb       (sh_msb)
  );

  sl_enable_decode #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_decode (
    .fire (state == ST_LATCH),
    .sel  (sel_q),
    .en   (latch_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_idx  <= '0;
      word_idx <= '0;
      sel_q    <= '0;
      div_q    <= '0;
      ref_q    <= '0;
      ncnt_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= frame_end;
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_PREP;
          bit_idx  <= '0;
          word_idx <= '0;
          sel_q    <= dev_sel;
          div_q    <= half_div;
          ref_q    <= ref_word;
          ncnt_q   <= ncnt_word;
        end
        ST_PREP:  if (tick) state <= ST_LOW;
        ST_LOW:   if (tick) state <= ST_HIGH;
        ST_HIGH: begin
          if (word_end)      state <= ST_LATCH;
          else if (shift_en) begin
            state   <= ST_LOW;
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_LATCH: begin
          if (frame_end) state <= ST_IDLE;
          else if (next_word) begin
            state    <= ST_PREP;
            word_idx <= word_idx + 1'b1;
            bit_idx  <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ser_clk  = (state == ST_HIGH);
  assign ser_data = ((state == ST_LOW) || (state == ST_HIGH)) && sh_msb;
  assign busy     = (state != ST_IDLE);
  assign done     = done_q;

  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
  p_latch_clk_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en != '0) |-> (!ser_clk && !ser_data));
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_data && (latch_en == '0)));
  p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(sel_q) && $stable(div_q) && $stable(ref_q)));
  p_word_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    next_word |=> (word_idx == 2'($past(word_idx) + 2'd1)));
endmodule

// File: tb/test_synth_word_loader.sv
module test_synth_word_loader;
  localparam int NDEV  = 3;
  localparam int SEL_W = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [SEL_W-1:0]  dev_sel;
  logic [7:0]        half_div;
  logic [31:0]       func_word, ref_word, ncnt_word;
  logic              ser_clk, ser_data, busy, done;
  logic [NDEV-1:0]   latch_en;

  always #5 clk = ~clk;

  synth_word_loader i_synth_word_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dev_sel   (dev_sel),
    .half_div  (half_div),
    .func_word (func_word),
    .ref_word  (ref_word),
    .ncnt_word (ncnt_word),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .latch_en  (latch_en),
    .busy      (busy),
    .done      (done)
  );

  int vectors = 0;
  int miscompares = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_word(input logic [31:0] w);
    return 24'(w % 32'h0100_0000);
  endfunction

  // Monitor state, cleared through clr
  logic            clr = 1'b0;
  int              exp_d = 1;
  int              busy_cnt, nbits, nlatch, hi_run, lo_run, la_run;
  int              done_cnt, done_bad, hi_err, lo_err, la_err, first_err;
  logic [23:0]     cur;
  logic [23:0]     got_w [3];
  logic [NDEV-1:0] got_d [3];
  logic            prev_clk, prev_busy, prev_la, seen_busy;

  always @(negedge clk) begin
    if (clr) begin
      busy_cnt = 0; nbits = 0; nlatch = 0; hi_run = 0; lo_run = 0; la_run = 0;
      done_cnt = 0; done_bad = 0; hi_err = 0; lo_err = 0; la_err = 0; first_err = 0;
      cur = '0; prev_clk = 1'b0; prev_busy = 1'b0; prev_la = 1'b0; seen_busy = 1'b0;
      for (int k = 0; k < 3; k++) begin got_w[k] = '0; got_d[k] = '0; end
    end else begin
      if (busy) begin
        busy_cnt++;
        if (!seen_busy) begin
          seen_busy = 1'b1;
          if (ser_clk || ser_data || latch_en != '0) first_err++;
        end
      end
      if (ser_clk) begin
        if (!prev_clk) begin
          if ((nbits % 24) != 0 && lo_run != exp_d) lo_err++;
          cur = {cur[22:0], ser_data};
          nbits++;
        end
        hi_run++;
        lo_run = 0;
      end else begin
        if (prev_clk) begin
          if (hi_run != exp_d) hi_err++;
          hi_run = 0;
        end
        lo_run++;
      end
      if (|latch_en) begin
        if (!prev_la) begin
          if (nlatch < 3) begin got_w[nlatch] = cur; got_d[nlatch] = latch_en; end
          nlatch++;
        end
        la_run++;
      end else if (prev_la) begin
        if (la_run != exp_d) la_err++;
        la_run = 0;
      end
      if (done) begin
        done_cnt++;
        if (busy || !prev_busy) done_bad++;
      end
      prev_clk  = ser_clk;
      prev_busy = busy;
      prev_la   = |latch_en;
    end
  end

  task automatic run_xfer(input logic [31:0] f, input logic [31:0] r, input logic [31:0] n,
                          input logic [SEL_W-1:0] s, input logic [7:0] d, input bit inject);
    int deff;
    int exp_nl;
    int guard;
    deff   = (d == 8'd0) ? 1 : int'(d);
    exp_nl = (int'(s) < NDEV) ? 3 : 0;
    @(posedge clk); #2;
    clr = 1'b1; exp_d = deff;
    @(posedge clk); #2;
    clr = 1'b0;
    func_word = f; ref_word = r; ncnt_word = n; dev_sel = s; half_div = d; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    if (inject) begin
      repeat (30) @(posedge clk);
      #2;
      func_word = ~f; ref_word = ~r; ncnt_word = ~n; dev_sel = s + 2'd1; half_div = d + 8'd3;
      start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
    end
    guard = 0;
    while (done_cnt == 0 && guard < 160 * deff + 100) begin
      @(posedge clk);
      guard++;
    end
    repeat (4) @(posedge clk);
    #2;
    chk(nlatch == exp_nl, "R6 latch pulse count", nlatch, exp_nl);
    if (exp_nl == 3) begin
      chk(got_w[0] == expect_word(f), "R3 first word is function word (R1 R2)", got_w[0], expect_word(f));
      chk(got_w[1] == expect_word(r), "R3 second word is reference word (R1 R2)", got_w[1], expect_word(r));
      chk(got_w[2] == expect_word(n), "R3 third word is feedback word (R1 R2)", got_w[2], expect_word(n));
      for (int k = 0; k < 3; k++)
        chk(got_d[k] == NDEV'(1 << s), "R6 selected enable only", got_d[k], 1 << s);
      chk(la_err == 0, "R6 latch pulse width", la_err, 0);
    end
    chk(nbits == 72, "R2 serial bit count", nbits, 72);
    chk(hi_err == 0 && lo_err == 0, "R5 clock phase widths", hi_err + lo_err, 0);
    chk(first_err == 0, "R4 lines low before first bit", first_err, 0);
    chk(busy_cnt == 150 * deff, "R7 busy length", busy_cnt, 150 * deff);
    chk(done_cnt == 1 && done_bad == 0, "R7 single done after busy", done_cnt + done_bad, 1);
    if (d == 8'd0)
      chk(busy_cnt == 150, "R9 zero divider acts as one", busy_cnt, 150);
    if (inject)
      chk(nlatch == exp_nl && busy_cnt == 150 * deff && nbits == 72,
          "R8 start while busy ignored", busy_cnt, 150 * deff);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL R7 watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; dev_sel = '0; half_div = 8'd1;
    func_word = '0; ref_word = '0; ncnt_word = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(!ser_clk && !ser_data && latch_en == '0 && !busy && !done, "R4 reset idle outputs",
        {ser_clk, ser_data, latch_en, busy, done}, 0);

    run_xfer(32'hFF80_0001, 32'h1234_5678, 32'hA5C3_3C5A, 2'd0, 8'd3, 1'b0);
    run_xfer(32'h00FF_FFFF, 32'hFF00_0000, 32'h0080_0001, 2'd1, 8'd0, 1'b0);
    run_xfer(32'h5555_AAAA, 32'h0F0F_0F0F, 32'hDEAD_BEEF, 2'd2, 8'd255, 1'b0);
    run_xfer(32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 2'd3, 8'd2, 1'b0);
    run_xfer(32'hCAFE_0410, 32'h0003_E801, 32'h009F_8092, 2'd2, 8'd4, 1'b1);

    void'($urandom(32'd1234));
    for (int t = 0; t < 10; t++) begin
      logic [31:0] rf, rr, rn;
      logic [SEL_W-1:0] rs;
      logic [7:0] rd;
      rf = $urandom; rr = $urandom; rn = $urandom;
      rs = SEL_W'($urandom % NDEV);
      rd = 8'(1 + ($urandom % 8));
      run_xfer(rf, rr, rn, rs, rd, (t % 4) == 3);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule